// File: doc/BRIEF.md
# Timing-Error-Detecting Pipeline Register Chain

This block is a chain of protected pipeline registers. Each stage adds a fixed increment to the value handed on by the stage before it and holds the result in a main flip-flop. A second, shadow copy of the same stage input is captured at the end of a delay window. The shadow copy stands in for data that settled too late for the main clock edge. A comparator flags any stage whose two copies disagree. That stage then forwards the shadow copy through a 2:1 select, so the value passed on is the late but correct one.

A disagreement is reported as a one-cycle per-stage error pulse and a flush request. At the same edge, every stage younger than the oldest failing stage loses its content. The upstream source replays the lost items after it sees the flush request. A saturating counter records how many mismatches have occurred.

In simulation, a late path is modelled by the per-stage `late_i` input. When it is high at a capture edge, the main flip-flop takes the stage value with bit 0 inverted. When `shadow_en_i` is high, the shadow copy takes the true value. The delayed clock itself is not modelled.

Top module: `tdet_pipe`

## Requirements
- R1: After reset, `out_valid_o`, `err_o`, `flush_o` and `err_count_o` are all zero.
- R2: Stage k (counting from 0) adds k+1. A valid item x with no late capture appears on `out_valid_o`/`out_data_o` after exactly STAGES rising edges, counting the edge that takes it in. Its value is x + STAGES*(STAGES+1)/2, modulo 2^WIDTH.
- R3: When `late_i[k]` is high at the edge where a valid item enters stage k, and `shadow_en_i` is high at that edge, the stage forwards the shadow value. The item still leaves with the value and latency of R2.
- R4: Such a late capture drives `err_o[k]` high for exactly one cycle: the cycle after the one that follows the capture edge.
- R5: `flush_o` is high in exactly the cycles in which any bit of `err_o` is high.
- R6: At the edge that ends a mismatch cycle, every stage with an index up to and including the oldest failing stage takes in no valid item. The items lost this way never reach the output. Older items and the corrected item still arrive. Each item leaves at most once, in issue order.
- R7: Without a late capture, no error pulse and no flush request occur.
- R8: With `shadow_en_i` low at the capture edge, a late capture raises no error. The main value, with bit 0 inverted, is forwarded.
- R9: `err_count_o` rises by the number of stages that show a mismatch in a cycle, and saturates at 2^CNT_W-1. The new value shows in the same cycle as the matching `err_o` pulse.
- R10: When several stages fail in the same cycle, `err_o` shows all of them. Invalidation then reaches up to the highest-index failing stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | New item offered to stage 0 |
| in_data_i | input | WIDTH | Value of the new item |
| late_i | input | STAGES | Per stage: the path into this stage misses the main edge |
| shadow_en_i | input | 1 | Enables shadow capture at the end of the delay window |
| out_valid_o | output | 1 | Last stage holds a valid item |
| out_data_o | output | WIDTH | Corrected value of the last stage |
| err_o | output | STAGES | One-cycle per-stage timing error pulse |
| flush_o | output | 1 | Request to replay the invalidated younger items |
| err_count_o | output | CNT_W | Saturating count of detected mismatches |

## Verification
Two things can fall into the same cycle: a stage correcting its own late capture, and the invalidation caused by an older stage failing at that moment. A cycle can also carry both a replayed item and a fresh mismatch. Directed stimulus drives late captures into two neighbouring stages at one edge. Random stimulus with frequent late bits makes such overlaps, and back-to-back flushes, common. A cycle-level reference model in the bench judges each case. It predicts the error vector, the reach of the invalidation, the saturating count and the output stream. A scoreboard checks that replayed items leave once each and in order.

// File: rtl/tdet_pkg.sv
package tdet_pkg;
  function automatic int stage_inc(int idx);
    return idx + 1;
  endfunction

  function automatic int chain_inc(int stages);
    return stages * (stages + 1) / 2;
  endfunction
endpackage

// File: rtl/tdet_stage.sv
module tdet_stage #(
  parameter int WIDTH     = 16,
  parameter int STAGE_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             late_i,
  input  logic             shadow_en_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             mismatch_o
);
  localparam int              INC_I = tdet_pkg::stage_inc(STAGE_IDX);
  localparam logic [WIDTH-1:0] INC  = INC_I[WIDTH-1:0];
  localparam logic [WIDTH-1:0] FLIP = WIDTH'(1);

  logic [WIDTH-1:0] sum_d, main_d, shad_d;
  logic [WIDTH-1:0] main_q, shad_q;
  logic             valid_q;

  assign sum_d  = data_i + INC;
  // late path: main edge sees an unsettled bit 0
  assign main_d = (valid_i && late_i) ? (sum_d ^ FLIP) : sum_d;
  assign shad_d = shadow_en_i ? sum_d : main_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      main_q  <= '0;
      shad_q  <= '0;
    end else begin
      valid_q <= valid_i && !kill_i;
      main_q  <= main_d;
      shad_q  <= shad_d;
    end
  end

  assign mismatch_o = valid_q && (main_q != shad_q);
  assign data_o     = mismatch_o ? shad_q : main_q;
  assign valid_o    = valid_q;

  a_r7_on_time_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(late_i) |-> !mismatch_o);

  a_r8_no_window_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(shadow_en_i) |-> !mismatch_o);

  a_r3_corrected_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(shadow_en_i)) |-> (data_o == $past(data_i) + INC));
endmodule

// File: rtl/tdet_flush_ctrl.sv
module tdet_flush_ctrl #(
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] mismatch_i,
  output logic [STAGES-1:0] kill_o,
  output logic [STAGES-1:0] err_o,
  output logic              flush_o
);
  logic [STAGES-1:0] err_q;
  logic              flush_q;

  // a failing stage and everything younger capture nothing
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = STAGES - 1; i >= 0; i--) begin
      acc       = acc | mismatch_i[i];
      kill_o[i] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      err_q   <= mismatch_i;
      flush_q <= |mismatch_i;
    end
  end

  assign err_o   = err_q;
  assign flush_o = flush_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_pulse
    a_r4_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q[g] |=> !err_q[g]);
  end
endmodule

// File: rtl/tdet_err_count.sv
module tdet_err_count #(
  parameter int STAGES = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] mismatch_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int               PC_W    = $clog2(STAGES + 1);
  localparam int               SUM_W   = CNT_W + PC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PC_W-1:0]  pc;
  logic [SUM_W-1:0] total;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    pc = '0;
    for (int i = 0; i < STAGES; i++) pc = pc + PC_W'(mismatch_i[i]);
  end

  assign total = SUM_W'(cnt_q) + SUM_W'(pc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (total > SUM_W'(CNT_MAX)) cnt_q <= CNT_MAX;
    else                              cnt_q <= total[CNT_W-1:0];
  end

  assign count_o = cnt_q;

  a_r9_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= $past(cnt_q));

  a_r9_bounded_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_q) - int'($past(cnt_q))) <= STAGES);
endmodule

// File: rtl/tdet_pipe.sv
module tdet_pipe #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [WIDTH-1:0]  in_data_i,
  input  logic [STAGES-1:0] late_i,
  input  logic              shadow_en_i,
  output logic              out_valid_o,
  output logic [WIDTH-1:0]  out_data_o,
  output logic [STAGES-1:0] err_o,
  output logic              flush_o,
  output logic [CNT_W-1:0]  err_count_o
);
  logic [STAGES-1:0] st_v, mis, kill, in_v;
  logic [WIDTH-1:0]  st_d [STAGES];
  logic [WIDTH-1:0]  in_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign in_v[g] = in_valid_i;
      assign in_d[g] = in_data_i;
    end else begin : g_body
      assign in_v[g] = st_v[g-1];
      assign in_d[g] = st_d[g-1];
    end

    tdet_stage #(
      .WIDTH    (WIDTH),
      .STAGE_IDX(g)
    ) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .kill_i     (kill[g]),
      .valid_i    (in_v[g]),
      .data_i     (in_d[g]),
      .late_i     (late_i[g]),
      .shadow_en_i(shadow_en_i),
      .valid_o    (st_v[g]),
      .data_o     (st_d[g]),
      .mismatch_o (mis[g])
    );

    a_r6_kill_reach: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mis[g] |=> !st_v[g]);
  end

  tdet_flush_ctrl #(.STAGES(STAGES)) u_flush (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mismatch_i(mis),
    .kill_o    (kill),
    .err_o     (err_o),
    .flush_o   (flush_o)
  );

  tdet_err_count #(.STAGES(STAGES), .CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mismatch_i(mis),
    .count_o   (err_count_o)
  );

  assign out_valid_o = st_v[STAGES-1];
  assign out_data_o  = st_d[STAGES-1];

  a_r5_flush_follows_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(|mis) |-> flush_o);
endmodule

// File: tb/tdet_pipe_tb.sv
module tdet_pipe_tb;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int CW = 4;
  localparam int C  = N * (N + 1) / 2;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [N-1:0]  late = '0;
  logic          sh_en = 1'b1;
  logic          out_valid, flush;
  logic [W-1:0]  out_data;
  logic [N-1:0]  err;
  logic [CW-1:0] err_cnt;

  always #5 clk = ~clk;

  tdet_pipe #(.WIDTH(W), .STAGES(N), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .late_i(late), .shadow_en_i(sh_en), .out_valid_o(out_valid),
    .out_data_o(out_data), .err_o(err), .flush_o(flush), .err_count_o(err_cnt)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // reference model state
  logic         m_v [N];
  logic [W-1:0] m_val [N];
  int           m_tag [N];
  logic [N-1:0] m_mis = '0, m_err = '0;
  int           m_cnt = 0;
  int           d_tag = 0;
  int           next_tag = 0, tag_hi = 0, next_retire = 0;
  int           rw_min = 0;
  bit           rw_pend = 1'b0, ord_chk = 1'b1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [N-1:0] kill, nv, nmis;
    logic [W-1:0] nval [N];
    int           ntag [N];
    kill = '0;
    for (int j = 0; j < N; j++)
      for (int k = j; k < N; k++) if (m_mis[k]) kill[j] = 1'b1;
    for (int k = 0; k < N; k++) if (m_mis[k] && m_cnt < CMAX) m_cnt++;
    m_err = m_mis;
    for (int j = 0; j < N; j++) begin
      logic vin; logic [W-1:0] dp, s; int tin;
      vin = (j == 0) ? in_valid : m_v[j-1];
      dp  = (j == 0) ? in_data  : m_val[j-1];
      tin = (j == 0) ? d_tag    : m_tag[j-1];
      s   = dp + W'(j + 1);
      if (vin && kill[j]) begin
        if (!rw_pend || tin < rw_min) rw_min = tin;
        rw_pend = 1'b1;
      end
      nv[j]   = vin && !kill[j];
      nval[j] = (vin && late[j] && !sh_en) ? (s ^ W'(1)) : s;
      ntag[j] = tin;
      nmis[j] = nv[j] && late[j] && sh_en;
    end
    for (int j = 0; j < N; j++) begin
      m_v[j] = nv[j]; m_val[j] = nval[j]; m_tag[j] = ntag[j];
    end
    m_mis = nmis;
  endtask

  task automatic compare();
    chk(out_valid == m_v[N-1], "R6", "out_valid", int'(out_valid), int'(m_v[N-1]));
    if (m_v[N-1])
      chk(out_data == m_val[N-1], "R3", "out_data", int'(out_data), int'(m_val[N-1]));
    chk(err == m_err, "R4", "err_o", int'(err), int'(m_err));
    chk(flush == (|m_err), "R5", "flush_o", int'(flush), int'(|m_err));
    chk(int'(err_cnt) == m_cnt, "R9", "err_count", int'(err_cnt), m_cnt);
    if (out_valid && ord_chk) begin
      int got;
      got = int'(out_data) - C;
      chk(got == next_retire, "R6", "retire order", got, next_retire);
      next_retire = got + 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare();
    if (flush && rw_pend) begin
      next_tag = rw_min;
      rw_pend  = 1'b0;
    end
  endtask

  task automatic issue(bit v, logic [N-1:0] lt, bit sh);
    in_valid = v;
    late     = lt;
    sh_en    = sh;
    if (v) begin
      d_tag   = next_tag;
      in_data = W'(next_tag);
      if (next_tag + 1 > tag_hi) tag_hi = next_tag + 1;
      next_tag++;
    end else begin
      d_tag   = 0;
      in_data = '0;
    end
    step();
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) issue(next_tag < tag_hi, '0, 1'b1);
  endtask

  initial begin
    int base, t;
    for (int j = 0; j < N; j++) begin m_v[j] = 1'b0; m_val[j] = '0; m_tag[j] = 0; end
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    chk(err == '0, "R1", "err_o", int'(err), 0);
    chk(flush == 1'b0, "R1", "flush_o", int'(flush), 0);
    chk(err_cnt == '0, "R1", "err_count", int'(err_cnt), 0);

    // R2 single clean item, latency N edges
    t = next_tag;
    issue(1'b1, '0, 1'b1);
    for (int i = 0; i < N - 2; i++) issue(1'b0, '0, 1'b1);
    chk(out_valid == 1'b0, "R2", "early out", int'(out_valid), 0);
    issue(1'b0, '0, 1'b1);
    chk(out_valid && int'(out_data) == t + C, "R2", "clean item", int'(out_data), t + C);

    // R7 clean stream
    for (int i = 0; i < 10; i++) issue(1'b1, '0, 1'b1);
    drain(6);
    chk(err_cnt == '0, "R7", "count after clean", int'(err_cnt), 0);

    // R3/R4/R5 late capture into stage 2
    base = int'(err_cnt);
    issue(1'b1, '0, 1'b1);
    issue(1'b0, '0, 1'b1);
    issue(1'b0, 4'b0100, 1'b1);
    issue(1'b0, '0, 1'b1);
    chk(err == 4'b0100, "R4", "stage2 pulse", int'(err), 4);
    chk(flush == 1'b1, "R5", "flush with pulse", int'(flush), 1);
    chk(int'(err_cnt) == base + 1, "R9", "count step", int'(err_cnt), base + 1);
    issue(1'b0, '0, 1'b1);
    chk(err == '0, "R4", "pulse width", int'(err), 0);
    drain(6);

    // R10 two stages fail together
    base = int'(err_cnt);
    issue(1'b1, '0, 1'b1);
    issue(1'b1, '0, 1'b1);
    issue(1'b0, '0, 1'b1);
    issue(1'b0, 4'b1100, 1'b1);
    issue(1'b0, '0, 1'b1);
    chk(err == 4'b1100, "R10", "dual pulse", int'(err), 12);
    chk(int'(err_cnt) == base + 2, "R10", "dual count", int'(err_cnt), base + 2);
    drain(12);

    // random traffic with replay (R3 R6 R10 R9)
    for (int i = 0; i < 1500; i++) begin
      logic [N-1:0] lt;
      for (int b = 0; b < N; b++) lt[b] = ($urandom % 8) == 0;
      if (next_tag < tag_hi) issue(1'b1, lt, 1'b1);
      else                   issue(($urandom % 4) != 0, lt, 1'b1);
    end
    drain(20);
    chk(next_retire == tag_hi, "R6", "all items retired", next_retire, tag_hi);
    chk(int'(err_cnt) == CMAX, "R9", "saturated", int'(err_cnt), CMAX);

    // R8 shadow window off: no error, main value forwarded
    ord_chk = 1'b0;
    t = next_tag;
    issue(1'b1, 4'b0001, 1'b0);
    for (int i = 0; i < N - 1; i++) issue(1'b0, '0, 1'b1);
    chk(out_valid && int'(out_data) != t + C, "R8", "uncorrected value", int'(out_data), t + C);
    chk(err == '0, "R8", "no pulse", int'(err), 0);
    chk(flush == 1'b0, "R8", "no flush", int'(flush), 0);
    drain(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule